// File: doc/BRIEF.md
# CAS Latency Read Data Pipeline

This block is the read side of a DRAM data path. A read command arrives together with a whole four-beat burst from the array side. The block holds that burst back for a programmed number of clock cycles, then drives it onto the bus one beat per cycle with a valid flag. The clock runs at twice the command rate, so the latency is counted in half command cycles. A latency of 2.5 command cycles is therefore a whole number of clock cycles.

The latency comes from a mode register write issued while the pipeline is idle. The latency code decides which stage of a fixed delay chain a new burst enters, and the stages upstream of that entry point are bypassed. A code for a latency the chain cannot realise is either mapped to a neighbouring setting or refused with a flag. A new read may be accepted while an earlier burst is still draining. A read spaced exactly one burst length after the previous accepted read streams out with no gap. A read spaced closer than that would collide with the burst in flight, so it is refused and reported.

Top module: `cas_read_pipe`

## Requirements
- R1: After a synchronous reset, `dq_valid`, `dq_out`, `rd_conflict` and `mrs_illegal` are 0, and `cl_hc` reads 6 (3 command cycles).
- R2: For a read accepted at clock edge e, `dq_valid` is high after edges e+L through e+L+3, where L is the `cl_hc` value in force at edge e.
- R3: The four beats appear in order: beat k is `rd_burst[k*DATA_W +: DATA_W]` as sampled with the command, and k=0 comes first.
- R4: A legal mode write at an idle edge sets `cl_hc` after that edge. Code 0 gives 4, code 1 gives 5, code 2 gives 6, code 3 gives 8 and code 4 gives 10. Code 5, a request for 1.5 command cycles, gives 5, the same as code 1.
- R5: Codes 6 and 7 leave `cl_hc` unchanged and raise `mrs_illegal` for the one cycle after the write edge.
- R6: A mode write is refused in the same way as R5 if it arrives on the same edge as `rd_cmd`, or while any burst is still in the chain or being output. In that case `cl_hc` is unchanged.
- R7: A read accepted exactly 4 cycles after the previous accepted read produces its first beat in the cycle right after that read's last beat, at every supported latency.
- R8: A read arriving 1 to 3 cycles after the last accepted read is dropped. It produces no beats, raises `rd_conflict` for the one cycle after its edge, and does not restart the spacing window.
- R9: `dq_out` is 0 in every cycle in which `dq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| mrs_wr | input | 1 | Mode register write strobe |
| mrs_code | input | 3 | Latency code carried by the mode write |
| rd_cmd | input | 1 | Read command strobe |
| rd_burst | input | BEATS*DATA_W | Parallel burst from the array, beat 0 in the low bits |
| dq_out | output | DATA_W | Bus data, registered |
| dq_valid | output | 1 | High while a beat is on the bus |
| rd_conflict | output | 1 | One-cycle pulse for a refused overlapping read |
| mrs_illegal | output | 1 | One-cycle pulse for a refused mode write |
| cl_hc | output | 4 | Latency currently in force, in clock cycles |

## Verification
A wrong entry stage or a slipped chain register shows up as a valid window that starts early or late. The bench flags this in the first cycle the window should have opened, L cycles after the command. A corrupted spacing counter either emits beats for a read that should have been refused, or drops a seamless read. The bench sees this as a conflict pulse one cycle after the edge, or as a gap or extra beat at the burst boundary. A mode register that takes a refused code shows the changed `cl_hc` on the cycle after the write.

// File: rtl/cas_pipe_pkg.sv
package cas_pipe_pkg;

  localparam int CODE_W = 3;
  localparam int LAT_W  = 4;

  typedef struct packed {
    logic             ok;
    logic [LAT_W-1:0] hc;
  } lat_dec_t;

  // Latency code to delay in clock cycles (half command cycles).
  // Code 5 is the 1.5-cycle request, realised with the 2.5-cycle stage set.
  function automatic lat_dec_t decode_code(input logic [CODE_W-1:0] code);
    lat_dec_t d;
    d.ok = 1'b1;
    case (code)
      3'd0:    d.hc = LAT_W'(4);
      3'd1:    d.hc = LAT_W'(5);
      3'd2:    d.hc = LAT_W'(6);
      3'd3:    d.hc = LAT_W'(8);
      3'd4:    d.hc = LAT_W'(10);
      3'd5:    d.hc = LAT_W'(5);
      default: begin
        d.ok = 1'b0;
        d.hc = '0;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cas_mode_reg.sv
module cas_mode_reg
  import cas_pipe_pkg::*;
#(
  parameter int RST_HC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  input  logic              busy,
  output logic [LAT_W-1:0]  cl_hc,
  output logic              illegal
);

  lat_dec_t dec;
  logic     take;

  always_comb begin
    dec  = decode_code(code);
    take = wr && dec.ok && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_hc   <= LAT_W'(RST_HC);
      illegal <= 1'b0;
    end else begin
      illegal <= wr && !take;
      if (take) cl_hc <= dec.hc;
    end
  end

endmodule

// File: rtl/cas_issue_gate.sv
module cas_issue_gate #(
  parameter int BEATS = 4,
  localparam int CW = (BEATS > 2) ? $clog2(BEATS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_cmd,
  output logic accept,
  output logic conflict
);

  logic [CW-1:0] cool_q;

  assign accept = rd_cmd && (cool_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cool_q   <= '0;
      conflict <= 1'b0;
    end else begin
      conflict <= rd_cmd && (cool_q != '0);
      if (accept)              cool_q <= CW'(BEATS - 1);
      else if (cool_q != '0)   cool_q <= cool_q - 1'b1;
    end
  end

endmodule

// File: rtl/cas_delay_line.sv
module cas_delay_line #(
  parameter int DEPTH = 10,
  parameter int PW    = 32,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [PW-1:0]    in_pay,
  input  logic [LAT_W-1:0] cl_hc,
  output logic             out_vld,
  output logic [PW-1:0]    out_pay,
  output logic             any_vld
);

  logic [LAT_W-1:0] ins_idx;
  logic [DEPTH-1:0] vbus;

  // A burst enters at stage DEPTH-L; stages ahead of it are bypassed.
  assign ins_idx = LAT_W'(DEPTH) - cl_hc;

  for (genvar i = 0; i < DEPTH; i++) begin : stg
    logic          v;
    logic [PW-1:0] p;
    logic          prv_v;
    logic [PW-1:0] prv_p;
    logic          take;

    if (i == 0) begin : g_head
      assign prv_v = 1'b0;
      assign prv_p = '0;
    end else begin : g_link
      assign prv_v = stg[i-1].v;
      assign prv_p = stg[i-1].p;
    end

    assign take = in_vld && (ins_idx == LAT_W'(i));

    always_ff @(posedge clk) begin
      if (rst) v <= 1'b0;
      else     v <= take | prv_v;
    end

    always_ff @(posedge clk) begin
      p <= take ? in_pay : prv_p;
    end

    assign vbus[i] = v;
  end

  assign out_vld = stg[DEPTH-1].v;
  assign out_pay = stg[DEPTH-1].p;
  assign any_vld = |vbus;

endmodule

// File: rtl/cas_serializer.sv
module cas_serializer #(
  parameter int DATA_W = 8,
  parameter int BEATS  = 4,
  localparam int LW = (BEATS > 2) ? $clog2(BEATS) : 1,
  localparam int HW = (BEATS - 1) * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld,
  input  logic [BEATS*DATA_W-1:0] pay,
  output logic [DATA_W-1:0]       dq,
  output logic                    dv,
  output logic                    active
);

  logic [HW-1:0] hold_q;
  logic [LW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq     <= '0;
      dv     <= 1'b0;
      left_q <= '0;
      hold_q <= '0;
    end else if (ld) begin
      dq     <= pay[DATA_W-1:0];
      hold_q <= pay[BEATS*DATA_W-1:DATA_W];
      left_q <= LW'(BEATS - 1);
      dv     <= 1'b1;
    end else if (left_q != '0) begin
      dq     <= hold_q[DATA_W-1:0];
      hold_q <= hold_q >> DATA_W;
      left_q <= left_q - 1'b1;
      dv     <= 1'b1;
    end else begin
      dq <= '0;
      dv <= 1'b0;
    end
  end

endmodule

// File: rtl/cas_read_pipe.sv
module cas_read_pipe
  import cas_pipe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BEATS      = 4,
  parameter int LAT_MAX_HC = 10,
  parameter int RST_HC     = 6,
  localparam int PW = BEATS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_wr,
  input  logic [CODE_W-1:0] mrs_code,
  input  logic              rd_cmd,
  input  logic [PW-1:0]     rd_burst,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_valid,
  output logic              rd_conflict,
  output logic              mrs_illegal,
  output logic [LAT_W-1:0]  cl_hc
);

  logic          accept;
  logic          tail_vld;
  logic [PW-1:0] tail_pay;
  logic          chain_busy;
  logic          ser_active;
  logic          busy;

  assign busy = chain_busy | ser_active | dq_valid | rd_cmd;

  cas_mode_reg #(.RST_HC(RST_HC)) u_mode (
    .clk(clk), .rst(rst), .wr(mrs_wr), .code(mrs_code), .busy(busy),
    .cl_hc(cl_hc), .illegal(mrs_illegal)
  );

  cas_issue_gate #(.BEATS(BEATS)) u_gate (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd),
    .accept(accept), .conflict(rd_conflict)
  );

  cas_delay_line #(.DEPTH(LAT_MAX_HC), .PW(PW), .LAT_W(LAT_W)) u_line (
    .clk(clk), .rst(rst), .in_vld(accept), .in_pay(rd_burst), .cl_hc(cl_hc),
    .out_vld(tail_vld), .out_pay(tail_pay), .any_vld(chain_busy)
  );

  cas_serializer #(.DATA_W(DATA_W), .BEATS(BEATS)) u_ser (
    .clk(clk), .rst(rst), .ld(tail_vld), .pay(tail_pay),
    .dq(dq_out), .dv(dq_valid), .active(ser_active)
  );

endmodule

// File: rtl/cas_read_pipe_chk.sv
module cas_read_pipe_chk #(
  parameter int DATA_W = 8,
  parameter int BEATS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mrs_wr,
  input logic              rd_cmd,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_valid,
  input logic              rd_conflict,
  input logic              mrs_illegal,
  input logic [3:0]        cl_hc
);

  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (dq_valid) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R3 / R7: every valid run is a whole number of bursts
  assert_whole_bursts_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_valid) |-> (run_q % BEATS) == 0);

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> dq_out == '0);

  assert_conflict_cause_R8: assert property (@(posedge clk) disable iff (rst)
    rd_conflict |-> $past(rd_cmd));

  assert_illegal_cause_R5: assert property (@(posedge clk) disable iff (rst)
    mrs_illegal |-> $past(mrs_wr));

  assert_lat_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(mrs_wr) |-> $stable(cl_hc));

  assert_lat_legal_R4: assert property (@(posedge clk) disable iff (rst)
    cl_hc == 4'd4 || cl_hc == 4'd5 || cl_hc == 4'd6 || cl_hc == 4'd8 || cl_hc == 4'd10);

endmodule

bind cas_read_pipe cas_read_pipe_chk #(.DATA_W(DATA_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst(rst), .mrs_wr(mrs_wr), .rd_cmd(rd_cmd), .dq_out(dq_out),
  .dq_valid(dq_valid), .rd_conflict(rd_conflict), .mrs_illegal(mrs_illegal),
  .cl_hc(cl_hc)
);

// File: tb/cas_read_pipe_tb_top.sv
module cas_read_pipe_tb_top;

  localparam int W = 8;
  localparam int NB = 4;
  localparam int HIST = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mrs_wr = 1'b0;
  logic [2:0]    mrs_code = '0;
  logic          rd_cmd = 1'b0;
  logic [NB*W-1:0] rd_burst = '0;
  logic [W-1:0]  dq_out;
  logic          dq_valid;
  logic          rd_conflict;
  logic          mrs_illegal;
  logic [3:0]    cl_hc;

  always #5 clk = ~clk;

  cas_read_pipe dut_i (
    .clk(clk), .rst(rst), .mrs_wr(mrs_wr), .mrs_code(mrs_code), .rd_cmd(rd_cmd),
    .rd_burst(rd_burst), .dq_out(dq_out), .dq_valid(dq_valid),
    .rd_conflict(rd_conflict), .mrs_illegal(mrs_illegal), .cl_hc(cl_hc)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit in_rst = 1'b1;
  int cl_m = 6;
  int last_acc = -100;
  int last_end = -100;
  bit exp_v [HIST];
  logic [W-1:0] exp_d [HIST];
  bit exp_c [HIST];
  bit exp_i [HIST];
  int run = 0;
  int max_run = 0;
  int conf_cnt = 0;
  int bcnt = 0;
  bit done = 1'b0;

  function automatic int exp_hc(input int code);
    case (code)
      0: return 4;
      1: return 5;
      2: return 6;
      3: return 8;
      4: return 10;
      5: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  // Reference model: evaluated on each rising edge from the sampled inputs
  always @(posedge clk) begin
    bit busy_m;
    cyc = cyc + 1;
    if (rst) begin
      in_rst = 1'b1;
      cl_m = 6;
      last_acc = -100;
      last_end = -100;
    end else begin
      in_rst = 1'b0;
      busy_m = rd_cmd || (last_end >= cyc - 1);
      if (rd_cmd) begin
        if (cyc - last_acc >= NB) begin
          for (int j = 0; j < NB; j++) begin
            exp_v[cyc + cl_m + j] = 1'b1;
            exp_d[cyc + cl_m + j] = rd_burst[j*W +: W];
          end
          last_acc = cyc;
          last_end = cyc + cl_m + NB - 1;
        end else begin
          exp_c[cyc] = 1'b1;
        end
      end
      if (mrs_wr) begin
        if (busy_m || mrs_code > 3'd5) exp_i[cyc] = 1'b1;
        else cl_m = exp_hc(int'(mrs_code));
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!in_rst && cyc > 0) begin
      chk(dq_valid == exp_v[cyc], "R2 dq_valid", int'(dq_valid), int'(exp_v[cyc]));
      if (exp_v[cyc])
        chk(dq_out == exp_d[cyc], "R3 dq_out", int'(dq_out), int'(exp_d[cyc]));
      else
        chk(dq_out == '0, "R9 dq_out idle", int'(dq_out), 0);
      chk(rd_conflict == exp_c[cyc], "R8 rd_conflict", int'(rd_conflict), int'(exp_c[cyc]));
      chk(mrs_illegal == exp_i[cyc], "R5 mrs_illegal", int'(mrs_illegal), int'(exp_i[cyc]));
      chk(int'(cl_hc) == cl_m, "R4 cl_hc", int'(cl_hc), cl_m);
    end
    if (dq_valid) run = run + 1;
    else run = 0;
    if (run > max_run) max_run = run;
    if (rd_conflict) conf_cnt = conf_cnt + 1;
  end

  task automatic idle(input int n);
    mrs_wr = 1'b0;
    rd_cmd = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_mrs(input int code);
    mrs_wr = 1'b1;
    mrs_code = 3'(code);
    @(negedge clk);
    mrs_wr = 1'b0;
  endtask

  task automatic do_rd();
    bcnt++;
    for (int j = 0; j < NB; j++) rd_burst[j*W +: W] = W'(bcnt * 16 + j * 5 + 1);
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dq_valid == 1'b0, "R1 dq_valid", int'(dq_valid), 0);
    chk(dq_out == '0, "R1 dq_out", int'(dq_out), 0);
    chk(rd_conflict == 1'b0, "R1 rd_conflict", int'(rd_conflict), 0);
    chk(mrs_illegal == 1'b0, "R1 mrs_illegal", int'(mrs_illegal), 0);
    chk(cl_hc == 4'd6, "R1 cl_hc", int'(cl_hc), 6);
    rst = 1'b0;
    idle(2);
    do_rd();
    idle(16);

    // R2 / R4: every code, one read each
    for (int c = 0; c < 6; c++) begin
      do_mrs(c);
      chk(int'(cl_hc) == exp_hc(c), (c == 5) ? "R4 alias" : "R2 code", int'(cl_hc), exp_hc(c));
      do_rd();
      idle(16);
    end

    // R5: refused codes
    do_mrs(3);
    idle(1);
    do_mrs(6);
    chk(cl_hc == 4'd8, "R5 code6", int'(cl_hc), 8);
    idle(1);
    do_mrs(7);
    chk(cl_hc == 4'd8, "R5 code7", int'(cl_hc), 8);
    idle(2);

    // R7: seamless triples at every latency
    for (int c = 0; c < 5; c++) begin
      do_mrs(c);
      idle(2);
      max_run = 0;
      do_rd(); idle(3);
      do_rd(); idle(3);
      do_rd();
      idle(16);
      chk(max_run == 3 * NB, "R7 seamless run", max_run, 3 * NB);
    end

    // R8: overlapping reads refused, window not restarted
    do_mrs(2);
    idle(2);
    max_run = 0;
    conf_cnt = 0;
    do_rd(); do_rd(); do_rd(); do_rd(); do_rd();
    idle(16);
    chk(conf_cnt == 3, "R8 conflict count", conf_cnt, 3);
    chk(max_run == 2 * NB, "R8 accepted run", max_run, 2 * NB);

    // R6: mode write while busy, and together with a read
    do_mrs(0);
    idle(2);
    do_rd();
    idle(2);
    do_mrs(4);
    chk(cl_hc == 4'd4, "R6 busy write", int'(cl_hc), 4);
    idle(16);
    mrs_wr = 1'b1;
    mrs_code = 3'd3;
    bcnt++;
    for (int j = 0; j < NB; j++) rd_burst[j*W +: W] = W'(bcnt * 16 + j * 5 + 1);
    rd_cmd = 1'b1;
    @(negedge clk);
    mrs_wr = 1'b0;
    rd_cmd = 1'b0;
    chk(cl_hc == 4'd4, "R6 write with read", int'(cl_hc), 4);
    idle(16);
    do_mrs(4);
    chk(cl_hc == 4'd10, "R4 idle write", int'(cl_hc), 10);
    do_rd();
    idle(20);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog expired: actual=1 expected=0");
      summary();
      $finish;
    end
  end

endmodule